// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs beside a small processor core and carries out the hardware part of entering an interrupt service routine. It watches a set of level-sensitive request lines. When the core signals that an instruction has retired and interrupts are globally enabled, it accepts the lowest-numbered pending request. It then acknowledges the chosen device and pushes the return address, followed by the status word, onto a downward-growing stack in memory. Only after those writes does it drive a one-cycle program counter load with the handler address.

The handler address comes from one of two sources, selected when the request is accepted. In vectored mode, the acknowledged device supplies an index, and the handler is the table base plus four bytes per entry. In common-handler mode, every request lands on one shared address, and software finds the source itself. The global enable drops on entry so that nothing can break into the save sequence. Software sets it again with a pulse, and it can also rewrite the stack pointer through a load hook that a return path uses.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `insn_done` is 1, `irq_en` is 1, at least one `irq_req` bit is 1, and the block is idle. Without all four, `ack` stays 0 and `busy` stays 0.
- R2: In the cycle after acceptance, `ack` is 1 for exactly one cycle. During that cycle `ack_grant` is one-hot, with bit k set for the lowest-numbered line k that was pending at acceptance. `vec_idx` is sampled in that same cycle.
- R3: In the cycle after `ack`, `mem_we` is 1, `mem_addr` is the stack pointer minus 4, and `mem_wdata` is the `cur_pc` value captured at acceptance.
- R4: In the next cycle (status push enabled, the default), `mem_we` is 1, `mem_addr` is the stack pointer minus 8, and `mem_wdata` is the `cur_status` captured at acceptance. The stack pointer ends 8 bytes lower.
- R5: In the cycle after the last push, `pc_load` is 1 for one cycle and `mem_we` is 0. In vectored mode `pc_target` is `vec_base + 4*vec_idx`. In common mode it is `common_addr`. The mode is the value of `vec_mode` at acceptance.
- R6: `pc_load` is never 1 unless a stack write took place in the cycle before it.
- R7: `irq_en` is 0 after reset and is cleared on acceptance. An `ie_set` pulse while idle sets it at the next edge. `ie_set` while busy is ignored.
- R8: `busy` is 1 from the cycle after acceptance through the `pc_load` cycle, and 0 otherwise. `irq_en` is 0 whenever `busy` is 1.
- R9: The stack pointer resets to `STACK_TOP` (default 0x0001_0000). An `sp_load` pulse while idle replaces it with `sp_load_val`. `sp_load` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Level request lines, held until acknowledged |
| insn_done | input | 1 | Instruction retired this cycle (boundary strobe) |
| cur_pc | input | ADDR_W | Return address offered by the core |
| cur_status | input | ADDR_W | Status word offered by the core |
| vec_mode | input | 1 | 1 = device-supplied vector, 0 = common handler |
| vec_base | input | ADDR_W | Vector table base address |
| common_addr | input | ADDR_W | Shared handler address |
| vec_idx | input | IDX_W | Device vector index, valid during `ack` |
| ack | output | 1 | Acknowledge pulse |
| ack_grant | output | NUM_IRQ | One-hot line being acknowledged |
| ie_set | input | 1 | Re-enable interrupts pulse |
| irq_en | output | 1 | Global interrupt enable |
| sp_load | input | 1 | Stack pointer restore strobe |
| sp_load_val | input | ADDR_W | Value for stack pointer restore |
| busy | output | 1 | Entry sequence in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | ADDR_W | Stack write address |
| mem_wdata | output | ADDR_W | Stack write data |
| pc_load | output | 1 | Program counter load strobe |
| pc_target | output | ADDR_W | Handler address to load |

## Verification
The assertions assume that `insn_done` is a single-cycle strobe. They also assume that a device keeps its request line high until it sees its `ack_grant` bit and then drops it, and that `sp_load` is used only with word-aligned values. The stimulus follows these rules by construction. Acknowledged lines are cleared in the `ack` cycle, the bench pulses `insn_done` one cycle at a time, and it builds every restore value with its low two bits zero. Misuse is injected only where the requirements say it must be ignored: `ie_set` and `sp_load` asserted mid-sequence, and stale `vec_idx` and `cur_pc` values driven after they have been captured.

// File: rtl/ies_pkg.sv
package ies_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACK     = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_PUSH_ST = 3'd3,
    ST_LOAD    = 3'd4
  } ies_state_e;
endpackage

// File: rtl/ies_prio.sv
module ies_prio #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic [NUM_IRQ-1:0] grant,
  output logic               any
);
  // Lowest index has highest priority.
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      grant[i] = req[i] & ~seen;
      seen     = seen | req[i];
    end
    any = seen;
  end

  always_comb begin
    a_r2_grant_onehot0: assert ($onehot0(grant));
  end
endmodule

// File: rtl/ies_stack.sv
module ies_stack #(
  parameter int          ADDR_W     = 32,
  parameter int          WORD_BYTES = 4,
  parameter int unsigned STACK_TOP  = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_data,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] SP_INIT = ADDR_W'(STACK_TOP);

  function automatic logic [ADDR_W-1:0] pre_dec(input logic [ADDR_W-1:0] p);
    return p - STEP;
  endfunction

  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] slot_addr;

  assign slot_addr = pre_dec(sp_q);
  assign mem_we    = push;
  assign mem_addr  = slot_addr;
  assign mem_wdata = push_data;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= SP_INIT;
    else if (push)    sp_q <= slot_addr;
    else if (load_en) sp_q <= load_val;
  end

  // R4: each push moves the pointer down by exactly one word
  a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp_q == $past(sp_q) - STEP));
  // R9: pointer is not reloaded during a push
  a_r9_no_load_in_push: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && load_en));
endmodule

// File: rtl/ies_vector.sv
module ies_vector #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              mode_vec,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [ADDR_W-1:0] common_addr,
  input  logic [IDX_W-1:0]  vec_idx,
  output logic [ADDR_W-1:0] target
);
  function automatic logic [ADDR_W-1:0] handler_addr(
    input logic              vmode,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] shared,
    input logic [IDX_W-1:0]  idx
  );
    logic [ADDR_W-1:0] off;
    off = ADDR_W'(idx) << 2;
    return vmode ? (base + off) : shared;
  endfunction

  logic [ADDR_W-1:0] target_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       target_q <= '0;
    else if (capture) target_q <= handler_addr(mode_vec, vec_base, common_addr, vec_idx);
  end

  assign target = target_q;

  // R5: target is word aligned in vectored mode when the base is
  a_r5_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && mode_vec && (vec_base[1:0] == 2'b00)) |=> (target[1:0] == 2'b00));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int          NUM_IRQ     = 8,
  parameter int          ADDR_W      = 32,
  parameter int          IDX_W       = 6,
  parameter int          WORD_BYTES  = 4,
  parameter int unsigned STACK_TOP   = 32'h0001_0000,
  parameter bit          PUSH_STATUS = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               insn_done,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic [ADDR_W-1:0]  cur_status,
  input  logic               vec_mode,
  input  logic [ADDR_W-1:0]  vec_base,
  input  logic [ADDR_W-1:0]  common_addr,
  input  logic [IDX_W-1:0]   vec_idx,
  output logic               ack,
  output logic [NUM_IRQ-1:0] ack_grant,
  input  logic               ie_set,
  output logic               irq_en,
  input  logic               sp_load,
  input  logic [ADDR_W-1:0]  sp_load_val,
  output logic               busy,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ADDR_W-1:0]  mem_wdata,
  output logic               pc_load,
  output logic [ADDR_W-1:0]  pc_target
);
  ies_state_e         state_q, state_d, after_pc;
  logic [NUM_IRQ-1:0] grant, win_q;
  logic               any_req, accept, push, idle;
  logic [ADDR_W-1:0]  pc_q, st_q, push_data;
  logic               mode_q, ie_q;

  // Named internal events
  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && ie_q && any_req && insn_done;
  assign push   = (state_q == ST_PUSH_PC) || (state_q == ST_PUSH_ST);

  generate
    if (PUSH_STATUS) begin : g_status
      assign after_pc = ST_PUSH_ST;
    end else begin : g_no_status
      assign after_pc = ST_LOAD;
    end
  endgenerate

  ies_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .req   (irq_req),
    .grant (grant),
    .any   (any_req)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_ACK;
      ST_ACK:     state_d = ST_PUSH_PC;
      ST_PUSH_PC: state_d = after_pc;
      ST_PUSH_ST: state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      pc_q    <= '0;
      st_q    <= '0;
      mode_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        win_q  <= grant;
        pc_q   <= cur_pc;
        st_q   <= cur_status;
        mode_q <= vec_mode;
        ie_q   <= 1'b0;
      end else if (idle && ie_set) begin
        ie_q <= 1'b1;
      end
    end
  end

  assign push_data = (state_q == ST_PUSH_ST) ? st_q : pc_q;

  ies_stack #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES),
    .STACK_TOP  (STACK_TOP)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .load_en   (sp_load && idle),
    .load_val  (sp_load_val),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  ies_vector #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_vector (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (state_q == ST_ACK),
    .mode_vec    (mode_q),
    .vec_base    (vec_base),
    .common_addr (common_addr),
    .vec_idx     (vec_idx),
    .target      (pc_target)
  );

  assign ack       = (state_q == ST_ACK);
  assign ack_grant = ack ? win_q : '0;
  assign pc_load   = (state_q == ST_LOAD);
  assign busy      = !idle;
  assign irq_en    = ie_q;

  // R1: acknowledge follows a boundary strobe with enable set
  a_r1_accept_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(insn_done && ie_q));
  // R2: acknowledge is a single-cycle pulse naming one line
  a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r2_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($countones(ack_grant) == 1));
  // R6: the handler load is always preceded by a stack write
  a_r6_save_before_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(mem_we));
  // R8: enable is low for the whole sequence
  a_r8_en_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_en);
  // R3: the save starts right after the acknowledge
  a_r3_push_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> mem_we);
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int N = 8;
  localparam int A = 32;
  localparam int I = 6;
  localparam logic [31:0] TOP    = 32'h0001_0000;
  localparam logic [31:0] BASE   = 32'h0000_4000;
  localparam logic [31:0] COMMON = 32'h0000_0800;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic         insn_done = 1'b0;
  logic [A-1:0] cur_pc = '0, cur_status = '0;
  logic         vec_mode = 1'b0;
  logic [A-1:0] vec_base = BASE, common_addr = COMMON;
  logic [I-1:0] vec_idx = '0;
  logic         ack;
  logic [N-1:0] ack_grant;
  logic         ie_set = 1'b0;
  logic         irq_en;
  logic         sp_load = 1'b0;
  logic [A-1:0] sp_load_val = '0;
  logic         busy, mem_we, pc_load;
  logic [A-1:0] mem_addr, mem_wdata, pc_target;

  int checks = 0;
  int fails  = 0;
  logic [A-1:0] msp;

  always #10 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
    .cur_pc(cur_pc), .cur_status(cur_status), .vec_mode(vec_mode),
    .vec_base(vec_base), .common_addr(common_addr), .vec_idx(vec_idx),
    .ack(ack), .ack_grant(ack_grant), .ie_set(ie_set), .irq_en(irq_en),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_load(pc_load), .pc_target(pc_target)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Winner: scan from the top down, keep the last set bit seen
  function automatic int lowest_line(input logic [N-1:0] r);
    int w;
    w = -1;
    for (int k = N - 1; k >= 0; k--) if (r[k]) w = k;
    return w;
  endfunction

  function automatic logic [A-1:0] exp_target(input bit vm, input logic [I-1:0] ix);
    if (vm) return BASE + (A'(ix) * 4);
    return COMMON;
  endfunction

  task automatic run_entry(input logic [N-1:0] req, input bit vm, input logic [I-1:0] ix,
                           input logic [A-1:0] pc, input logic [A-1:0] st, input bit poke);
    int ln;
    logic [N-1:0] oh;
    ln = lowest_line(req);
    oh = N'(1) << ln;
    irq_req = req; insn_done = 1'b1; cur_pc = pc; cur_status = st; vec_mode = vm;
    tick();
    insn_done = 1'b0;
    check(ack === 1'b1, "R2 ack pulse", 64'(ack), 64'd1);
    check(ack_grant === oh, "R2 lowest line granted", 64'(ack_grant), 64'(oh));
    check(irq_en === 1'b0 && busy === 1'b1, "R7/R8 enable cleared, busy",
          64'({irq_en, busy}), 64'b01);
    vec_idx = ix;
    irq_req[ln] = 1'b0;
    cur_pc = ~pc; cur_status = ~st; vec_mode = ~vm;
    if (poke) begin
      ie_set = 1'b1; sp_load = 1'b1; sp_load_val = 32'h0000_0100;
    end
    tick();
    ie_set = 1'b0; sp_load = 1'b0;
    vec_idx = ~ix;
    check(ack === 1'b0, "R2 ack single cycle", 64'(ack), 64'd0);
    check(mem_we === 1'b1 && mem_addr === msp - 4, "R3 pc push address",
          64'(mem_addr), 64'(msp - 4));
    check(mem_wdata === pc, "R3 pc push data", 64'(mem_wdata), 64'(pc));
    tick();
    check(mem_we === 1'b1 && mem_addr === msp - 8, "R4 status push address",
          64'(mem_addr), 64'(msp - 8));
    check(mem_wdata === st, "R4 status push data", 64'(mem_wdata), 64'(st));
    tick();
    check(pc_load === 1'b1 && mem_we === 1'b0, "R5/R6 load after save",
          64'({pc_load, mem_we}), 64'b10);
    check(pc_target === exp_target(vm, ix), "R5 handler address",
          64'(pc_target), 64'(exp_target(vm, ix)));
    msp = msp - 8;
    tick();
    check(busy === 1'b0 && pc_load === 1'b0, "R8 sequence ends",
          64'({busy, pc_load}), 64'b00);
    check(irq_en === 1'b0, "R7 ie_set while busy ignored", 64'(irq_en), 64'd0);
    irq_req = '0;
    ie_set = 1'b1;
    tick();
    ie_set = 1'b0;
    check(irq_en === 1'b1, "R7 ie_set in idle", 64'(irq_en), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    msp = TOP;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(irq_en === 1'b0 && busy === 1'b0 && ack === 1'b0, "R7/R8 reset state",
          64'({irq_en, busy, ack}), 64'b000);
    check(mem_we === 1'b0 && pc_load === 1'b0, "R6 reset no strobes",
          64'({mem_we, pc_load}), 64'b00);

    // R1/R7: requests with enable low are not taken at a boundary
    irq_req = 8'h10; insn_done = 1'b1;
    for (int c = 0; c < 3; c++) begin
      tick();
      check(ack === 1'b0 && busy === 1'b0, "R1 disabled request ignored",
            64'({ack, busy}), 64'b00);
    end
    insn_done = 1'b0; ie_set = 1'b1;
    tick();
    ie_set = 1'b0;
    // R1: enabled but no boundary strobe
    for (int c = 0; c < 3; c++) begin
      tick();
      check(ack === 1'b0 && busy === 1'b0, "R1 waits for boundary",
            64'({ack, busy}), 64'b00);
    end

    // Directed corners (R9 reset pointer used by the first entry)
    run_entry(8'hFF, 1'b1, 6'd63, 32'h0000_1234, 32'h0000_00A5, 1'b0);
    run_entry(8'h80, 1'b0, 6'd5,  32'hDEAD_BEE0, 32'h1111_2222, 1'b1);
    run_entry(8'h28, 1'b1, 6'd0,  32'h0000_0040, 32'h0, 1'b1);

    // R9: stack pointer restore in idle
    sp_load = 1'b1; sp_load_val = 32'h0000_2000;
    tick();
    sp_load = 1'b0;
    msp = 32'h0000_2000;
    run_entry(8'h06, 1'b1, 6'd17, 32'h0000_8888, 32'h0000_0003, 1'b0);

    for (int n = 0; n < 30; n++) begin
      logic [N-1:0] rq;
      rq = N'($urandom_range(1, 255));
      if ($urandom % 5 == 0) begin
        sp_load = 1'b1;
        sp_load_val = {16'h0, 16'($urandom_range(16'h1000, 16'hFFF0)) & 16'hFFFC};
        tick();
        sp_load = 1'b0;
        msp = sp_load_val;
      end
      run_entry(rq, 1'($urandom % 2), I'($urandom), $urandom, $urandom, ($urandom % 4 == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule